// File: doc/BRIEF.md
# Sampled Position/Velocity Parallel Read Port

This block sits between a pair of free-running tracking integrators and a 12-bit parallel host bus. A falling edge on the active-low sample strobe freezes the current angle and angular rate together into two holding registers. The integrators keep running. A rising edge of the same strobe emits a one-cycle pulse that clears the extreme-value registers of an external signal-magnitude monitor.

A host reads either held value by driving the select line, then pulling chip-select and the read strobe low. The falling edge of the read strobe, qualified by chip-select, copies the chosen holding register into an output register. That register drives the bus whenever the output enable is high. The output enable is asserted only while chip-select and read are both low and the mode line selects parallel operation. All three strobes cross into the system clock domain through two-flop synchronizers before their edges are detected.

Top module: `pv_read_port`

## Requirements
- R1: A sample falling edge copies the position input and the velocity input into their holding registers on the same clock edge. The read value equals the integrator values present at that moment.
- R2: The held values do not follow the integrators between sample falling edges. A read after the integrators have moved still returns the values captured at the last sample.
- R3: A sample rising edge produces exactly one single-cycle pulse on `mon_clr`. A sample falling edge produces none.
- R4: When `sel_pos` is 1 a read returns the position register (12-bit unsigned angle). When it is 0 a read returns the velocity register (12-bit two's complement rate).
- R5: `bus_oe` is 1 only while `cs_n` and `rd_n` are both low and `par_mode` is 1, delayed by the synchronizers. It returns to 0 after either strobe goes high.
- R6: A falling edge of `rd_n` with `cs_n` low loads the output register `bus_q`. `bus_q` then holds its value, even across new samples, until the next qualifying read falling edge.
- R7: With `par_mode` at 0 a read does not load `bus_q` and `bus_oe` stays 0, so bits 0 to 9 of the bus (and the rest) are undriven.
- R8: If a sample falling edge and a qualifying read falling edge are detected in the same cycle, the read returns the newly sampled value.
- R9: After reset `bus_q` is 0, `bus_oe` is 0 and `mon_clr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | 12 | Live angle from the position integrator |
| vel_in | input | 12 | Live rate from the velocity integrator |
| smp_n | input | 1 | Active-low sample strobe |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read strobe |
| sel_pos | input | 1 | 1 selects position, 0 selects velocity |
| par_mode | input | 1 | 1 enables the parallel port |
| bus_q | output | 12 | Output register contents for the data bus |
| bus_oe | output | 1 | Bus drive enable, 0 means high-impedance |
| mon_clr | output | 1 | One-cycle clear pulse for the monitor extremes |

## Verification
Random angle and rate pairs are sampled and then read with both select values. Directed cases alternate the select line, which shows whether the two registers are kept apart. Integrators that move after the sample show whether the values are frozen or merely tracked. A sample taken without a following read shows that the output register holds its value. Reads with the mode line low show that no load happens and the bus is never enabled. A sample and a read that fall together show which update takes priority.

// File: rtl/pv_read_port.sv
module pv_read_port #(
  parameter int W    = 12,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos_in,
  input  logic [W-1:0] vel_in,
  input  logic         smp_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         sel_pos,
  input  logic         par_mode,
  output logic [W-1:0] bus_q,
  output logic         bus_oe,
  output logic         mon_clr
);

  logic [SYNC-1:0] smp_sh, cs_sh, rd_sh;
  logic            smp_d, rd_d;
  logic [W-1:0]    pos_h, vel_h;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp_sh <= '1;
      cs_sh  <= '1;
      rd_sh  <= '1;
      smp_d  <= 1'b1;
      rd_d   <= 1'b1;
    end else begin
      smp_sh <= {smp_sh[SYNC-2:0], smp_n};
      cs_sh  <= {cs_sh[SYNC-2:0], cs_n};
      rd_sh  <= {rd_sh[SYNC-2:0], rd_n};
      smp_d  <= smp_sh[SYNC-1];
      rd_d   <= rd_sh[SYNC-1];
    end

  wire smp_s    = smp_sh[SYNC-1];
  wire cs_s     = cs_sh[SYNC-1];
  wire rd_s     = rd_sh[SYNC-1];
  wire smp_fall = smp_d & ~smp_s;
  wire smp_rise = ~smp_d & smp_s;
  wire rd_load  = rd_d & ~rd_s & ~cs_s & par_mode;

  wire [W-1:0] pos_nx = smp_fall ? pos_in : pos_h;
  wire [W-1:0] vel_nx = smp_fall ? vel_in : vel_h;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_h   <= '0;
      vel_h   <= '0;
      bus_q   <= '0;
      bus_oe  <= 1'b0;
      mon_clr <= 1'b0;
    end else begin
      pos_h   <= pos_nx;
      vel_h   <= vel_nx;
      mon_clr <= smp_rise;
      bus_oe  <= par_mode & ~cs_s & ~rd_s;
      if (rd_load) bus_q <= sel_pos ? pos_nx : vel_nx;
    end

endmodule

module pv_read_port_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic         par_mode,
  input logic [W-1:0] pos_h,
  input logic [W-1:0] bus_q,
  input logic         bus_oe,
  input logic         mon_clr
);
  AST_HOLD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(pos_h) |-> !$past(smp_n, 3)); // R1
  AST_CLR_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) mon_clr |=> !mon_clr); // R3
  AST_OE_STROBES:     assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> (!$past(rd_n, 3) && !$past(cs_n, 3))); // R5
  AST_OE_MODE:        assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> $past(par_mode)); // R7
  AST_LOAD_WITH_OE:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(bus_q) |-> bus_oe); // R6
endmodule

bind pv_read_port pv_read_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_n(smp_n), .cs_n(cs_n), .rd_n(rd_n),
  .par_mode(par_mode), .pos_h(pos_h), .bus_q(bus_q), .bus_oe(bus_oe), .mon_clr(mon_clr)
);

// File: tb/sim_pv_read_port.sv
module sim_pv_read_port;
  logic clk = 0, rst_n = 0;
  logic [11:0] pos_in = 0, vel_in = 0;
  logic smp_n = 1, cs_n = 1, rd_n = 1, sel_pos = 1, par_mode = 1;
  logic [11:0] bus_q;
  logic bus_oe, mon_clr;
  int n_run = 0, n_fail = 0, n_clr = 0;
  logic [11:0] mp, mv;

  always #4 clk = ~clk;

  pv_read_port u0 (.clk(clk), .rst_n(rst_n), .pos_in(pos_in), .vel_in(vel_in),
    .smp_n(smp_n), .cs_n(cs_n), .rd_n(rd_n), .sel_pos(sel_pos), .par_mode(par_mode),
    .bus_q(bus_q), .bus_oe(bus_oe), .mon_clr(mon_clr));

  always @(negedge clk) if (mon_clr) n_clr++;

  function automatic logic [11:0] pick(logic s, logic [11:0] p, logic [11:0] v);
    return s ? p : v;
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_sample(logic [11:0] p, logic [11:0] v);
    pos_in = p; vel_in = v; smp_n = 0;
    wait_n(5);
    pos_in = $urandom; vel_in = $urandom;
    smp_n = 1;
    wait_n(5);
    mp = p; mv = v;
  endtask

  task automatic do_read(logic s, string req);
    sel_pos = s; cs_n = 0; rd_n = 0;
    wait_n(5);
    chk(req, bus_q, pick(s, mp, mv));
    chk({req, " oe"}, {11'd0, bus_oe}, {11'd0, par_mode});
    rd_n = 1; cs_n = 1;
    wait_n(5);
    chk("R5 oe release", {11'd0, bus_oe}, 12'd0);
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    void'($urandom(32'h5eed1205));
    wait_n(3);
    chk("R9 bus", bus_q, 12'd0);
    chk("R9 oe", {11'd0, bus_oe}, 12'd0);
    chk("R9 clr", {11'd0, mon_clr}, 12'd0);
    rst_n = 1;
    wait_n(3);

    n_clr = 0;
    do_sample(12'hABC, 12'h812);
    chk("R3 one pulse per sample", n_clr[11:0], 12'd1);
    do_read(1, "R1 R4 position");
    do_read(0, "R1 R4 velocity");
    pos_in = 12'h111; vel_in = 12'h222;
    wait_n(6);
    do_read(1, "R2 frozen position");

    // R6 hold across new sample without read
    do_sample(12'h0F0, 12'h7FF);
    chk("R6 hold after sample", bus_q, 12'hABC);
    do_read(0, "R6 next read loads velocity");

    // R7 serial mode: no load, no drive
    do_sample(12'hFFF, 12'h000);
    par_mode = 0;
    wait_n(2);
    sel_pos = 1; cs_n = 0; rd_n = 0;
    wait_n(5);
    chk("R7 no drive", {11'd0, bus_oe}, 12'd0);
    chk("R7 no load", bus_q, 12'h7FF);
    rd_n = 1; cs_n = 1;
    wait_n(5);
    par_mode = 1;
    wait_n(2);

    // R8 simultaneous sample and read
    pos_in = 12'h5A5; vel_in = 12'hA5A; sel_pos = 1;
    smp_n = 0; cs_n = 0; rd_n = 0;
    wait_n(5);
    chk("R8 read sees new sample", bus_q, 12'h5A5);
    rd_n = 1; cs_n = 1; smp_n = 1;
    wait_n(5);
    mp = 12'h5A5; mv = 12'hA5A;
    do_read(0, "R8 velocity also new");

    n_clr = 0;
    for (int i = 0; i < 30; i++) begin
      logic [11:0] p, v;
      p = $urandom; v = $urandom;
      do_sample(p, v);
      do_read($urandom_range(0, 1), "R1 R4 random");
    end
    chk("R3 pulse count", n_clr[11:0], 12'd30);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule